// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Controller

This block frees an I2C bus that a target device has left in a bad state, for example after the master was reset in the middle of a transfer. It sits next to an I2C master and shares the open-drain lines with it. On a start request it first releases both lines and checks that SCL floats high. If SCL stays low, it gives up at once and reports a clock fault. If SCL is free but SDA is held low, it clocks SCL one pulse at a time. It samples SDA at the end of every high phase and stops pulsing as soon as the device lets go.

Once SDA is free, the block always closes with a STOP condition. This leaves the bus idle, and a device that was stopped in the middle of a write cycle drops the write instead of completing it with junk data. The outputs only pull the lines low. A line is released by letting the external pull-up raise it. The length of each SCL half period is set by a divider input that is captured at start.

Top module: `i2c_bus_recover`

## Requirements
- R1: Out of reset and while idle, `scl_pull`, `sda_pull` and `done` are all 0.
- R2: While pulsing, each SCL low phase and each SCL high phase lasts max(`half_div`,1) clock cycles while SCL reads high. `half_div` is captured in the cycle that `start` is accepted.
- R3: At the end of each high phase, SDA is sampled. Pulsing stops after the first pulse whose high phase ends with SDA high, so a device that releases after k pulses gets exactly k pulses.
- R4: At most MAX_PULSES (9) pulses are issued. If SDA is still low at the end of the ninth, the block finishes with `err_sda`=1, issues no STOP and releases both lines.
- R5: The STOP sequence is: pull SCL low for one half period, add SDA low for one half period, release SCL, then release SDA one half period after SCL reads high. `ok`=1 follows one half period later if SDA reads high. `sda_pull` only rises while SCL is pulled low, so no START is ever produced.
- R6: If SCL reads low for TMO_CYC cycles during the initial check, the block finishes with `err_scl`=1 and issues no pulse. `done` is high TMO_CYC cycles after the edge that accepted `start`.
- R7: While released SCL reads low (clock stretching), the phase counter pauses. Stretching shorter than TMO_CYC is tolerated. If SCL stays low for TMO_CYC cycles in a released phase, the block finishes with `err_scl`=1.
- R8: `done` is high for exactly one cycle. In that cycle exactly one of `ok`, `err_scl` and `err_sda` is 1, and these flags hold their value until the next accepted `start`.
- R9: A `start` pulse that arrives while a recovery is running is ignored: the pulse count and the single `done` are unchanged.
- R10: If SDA already reads high when SCL is found high, no pulse is issued. Only the STOP sequence runs, and the block finishes with `ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a recovery (accepted only when idle) |
| half_div | input | DIV_W | SCL half period in clocks (0 is treated as 1) |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| done | output | 1 | One-cycle end-of-recovery pulse |
| ok | output | 1 | Bus freed and STOP issued |
| err_scl | output | 1 | SCL could not be released high |
| err_sda | output | 1 | SDA still low after the last allowed pulse |

## Verification
The bench models a device that holds SDA until a chosen number of SCL rising edges has passed. Hold counts from 0 to 11 are picked at random together with divider values from 0 to 3. Hold count 0 separates the STOP-only path from the pulsing path. Counts 1 to 9 check exact early termination and the half-period length. Counts 10 and 11 check the failure at the cap with no STOP. Directed cases force SCL low before start, stretch the first high phase briefly or forever, and inject a second start mid-run. These cases tell timeout, stretch tolerance and start rejection apart.

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int DIV_W      = 8,
  parameter int TMO_W      = 16,
  parameter int TMO_CYC    = 1000,
  parameter int MAX_PULSES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_div,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             done,
  output logic             ok,
  output logic             err_scl,
  output logic             err_sda
);
  localparam int PC_W = $clog2(MAX_PULSES + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);
  localparam logic [PC_W-1:0]  PC_MAX   = PC_W'(MAX_PULSES);

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_LOW, S_HIGH, S_SL1, S_SL2, S_SHI, S_SREL
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] hp_q, cnt;
  logic [TMO_W-1:0] tcnt;
  logic [PC_W-1:0]  pcnt;

  wire half_end = (cnt == hp_q - 1'b1);
  wire tmo_hit  = (tcnt == TMO_LAST);

  assign scl_pull = (st == S_LOW) || (st == S_SL1) || (st == S_SL2);
  assign sda_pull = (st == S_SL2) || (st == S_SHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      hp_q    <= '0;
      cnt     <= '0;
      tcnt    <= '0;
      pcnt    <= '0;
      done    <= 1'b0;
      ok      <= 1'b0;
      err_scl <= 1'b0;
      err_sda <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          hp_q    <= (half_div == '0) ? DIV_W'(1) : half_div;
          cnt     <= '0;
          tcnt    <= '0;
          pcnt    <= '0;
          ok      <= 1'b0;
          err_scl <= 1'b0;
          err_sda <= 1'b0;
          st      <= S_CHK;
        end
        S_CHK: begin
          if (scl_in) begin
            cnt <= '0;
            st  <= sda_in ? S_SL1 : S_LOW;
          end else if (tmo_hit) begin
            err_scl <= 1'b1;
            done    <= 1'b1;
            st      <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_LOW: begin
          if (half_end) begin
            cnt  <= '0;
            tcnt <= '0;
            pcnt <= pcnt + 1'b1;
            st   <= S_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (!scl_in) begin
            if (tmo_hit) begin
              err_scl <= 1'b1;
              done    <= 1'b1;
              st      <= S_IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end else if (half_end) begin
            cnt <= '0;
            if (sda_in) begin
              st <= S_SL1;
            end else if (pcnt == PC_MAX) begin
              err_sda <= 1'b1;
              done    <= 1'b1;
              st      <= S_IDLE;
            end else begin
              st <= S_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SL1: begin
          if (half_end) begin
            cnt <= '0;
            st  <= S_SL2;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SL2: begin
          if (half_end) begin
            cnt  <= '0;
            tcnt <= '0;
            st   <= S_SHI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SHI: begin
          if (!scl_in) begin
            if (tmo_hit) begin
              err_scl <= 1'b1;
              done    <= 1'b1;
              st      <= S_IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end else if (half_end) begin
            cnt <= '0;
            st  <= S_SREL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SREL: begin
          if (half_end) begin
            ok      <= sda_in;
            err_sda <= !sda_in;
            done    <= 1'b1;
            st      <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PC_MAX);

  a_r5_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (scl_pull && $past(scl_pull)));

  a_r5_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_pull);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({ok, err_scl, err_sda}) == 1));

  a_r1_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_pull && !sda_pull));

endmodule

// File: tb/i2c_bus_recover_bench.sv
module i2c_bus_recover_bench;
  localparam int TMO = 120;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic       scl_pull, sda_pull, done, ok, err_scl, err_sda;
  logic       scl_hold = 1'b0, force_scl = 1'b0, dev_low = 1'b0;
  wire        scl_in = !(scl_pull || scl_hold || force_scl);
  wire        sda_in = !(sda_pull || dev_low);

  always #10 clk = ~clk;

  i2c_bus_recover #(.DIV_W(8), .TMO_W(16), .TMO_CYC(TMO), .MAX_PULSES(9)) u_i2c_bus_recover (
    .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .done(done), .ok(ok), .err_scl(err_scl), .err_sda(err_sda));

  int total = 0, bad = 0;
  bit finished = 0;
  int dev_rem, hold_cnt, stretch_req, episodes, cur_len, first_len, start_bad, done_cnt;
  bit stretch_used, stop_seen, prev_pull, prev_spull, prev_scl;
  bit r_ok, r_escl, r_esda;
  int lat;

  task automatic chk(bit cond, string req, string what, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    bit scl_now;
    @(negedge clk);
    if (!scl_pull && prev_pull && episodes == 1 && stretch_req > 0 && !stretch_used) begin
      hold_cnt = stretch_req;
      stretch_used = 1;
    end
    scl_hold = (hold_cnt > 0);
    if (hold_cnt > 0) hold_cnt--;
    scl_now = !(scl_pull || scl_hold || force_scl);
    if (scl_now && !prev_scl && dev_rem > 0) dev_rem--;
    dev_low = (dev_rem > 0);
    if (scl_pull && !prev_pull) begin episodes++; cur_len = 0; end
    if (scl_pull) cur_len++;
    if (!scl_pull && prev_pull && episodes == 1) first_len = cur_len;
    if (sda_pull && !prev_spull && scl_now) start_bad++;
    if (!sda_pull && prev_spull && scl_now) stop_seen = 1;
    if (done) done_cnt++;
    prev_pull = scl_pull; prev_spull = sda_pull; prev_scl = scl_now;
  endtask

  function automatic int exp_eps(int k);
    return (k > 9) ? 9 : k + 1;
  endfunction

  function automatic int exp_half(int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic run(int k, int n, int str, bit fscl, bit mid);
    bit got = 0;
    dev_rem = k; dev_low = (k > 0);
    stretch_req = str; stretch_used = 0; hold_cnt = 0;
    episodes = 0; cur_len = 0; first_len = 0; start_bad = 0; done_cnt = 0; stop_seen = 0;
    force_scl = fscl;
    half_div = 8'(n);
    tick;
    start = 1'b1;
    lat = 0;
    while (!got && lat < 5000) begin
      tick;
      lat++;
      if (lat == 1) start = 1'b0;
      if (mid && lat == 6) start = 1'b1;
      if (mid && lat == 7) start = 1'b0;
      if (done) begin got = 1; r_ok = ok; r_escl = err_scl; r_esda = err_sda; end
    end
    half_div = 8'd3;
    repeat (3) tick;
    chk(got, "R8", "done seen", int'(got), 1);
    chk(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
    chk(ok == r_ok && err_scl == r_escl && err_sda == r_esda, "R8", "flags held",
        int'({ok, err_scl, err_sda}), int'({r_ok, r_escl, r_esda}));
    chk(!scl_pull && !sda_pull, "R1", "lines released after done", int'({scl_pull, sda_pull}), 0);
    chk(start_bad == 0, "R5", "no START from block", start_bad, 0);
    force_scl = 1'b0; hold_cnt = 0; scl_hold = 1'b0; dev_rem = 0; dev_low = 1'b0;
    repeat (2) tick;
  endtask

  task automatic check_normal(int k, int n, string tag);
    chk(episodes == exp_eps(k), tag, "SCL low episodes", episodes, exp_eps(k));
    chk(r_ok == (k <= 9), tag, "ok flag", int'(r_ok), int'(k <= 9));
    chk(r_esda == (k > 9), "R4", "err_sda flag", int'(r_esda), int'(k > 9));
    chk(r_escl == 0, tag, "err_scl clear", int'(r_escl), 0);
    chk(stop_seen == (k <= 9), "R5", "STOP issued", int'(stop_seen), int'(k <= 9));
    if (k == 0)
      chk(first_len == 2 * exp_half(n), "R10", "STOP-only low length", first_len, 2 * exp_half(n));
    else
      chk(first_len == exp_half(n), "R2", "first low phase length", first_len, exp_half(n));
  endtask

  initial begin
    prev_pull = 0; prev_spull = 0; prev_scl = 1; dev_rem = 0; hold_cnt = 0; stretch_req = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!scl_pull && !sda_pull && !done, "R1", "reset state", int'({scl_pull, sda_pull, done}), 0);
    rst_n = 1'b1;
    repeat (2) tick;
    chk(!scl_pull && !sda_pull && !done, "R1", "idle after reset", int'({scl_pull, sda_pull, done}), 0);

    run(0, 2, 0, 0, 0); check_normal(0, 2, "R10");
    run(1, 0, 0, 0, 0); check_normal(1, 0, "R3");
    run(9, 1, 0, 0, 0); check_normal(9, 1, "R4");
    run(10, 1, 0, 0, 0); check_normal(10, 1, "R4");

    for (int i = 0; i < 24; i++) begin
      int k = int'($urandom % 12);
      int n = int'($urandom % 4);
      run(k, n, 0, 0, 0);
      check_normal(k, n, (k > 9) ? "R4" : "R3");
    end

    run(3, 2, 0, 1, 0);
    chk(r_escl == 1 && r_ok == 0, "R6", "err_scl on stuck SCL", int'(r_escl), 1);
    chk(episodes == 0, "R6", "no pulse with stuck SCL", episodes, 0);
    chk(lat == TMO + 1, "R6", "timeout latency", lat, TMO + 1);

    run(4, 2, 30, 0, 0);
    check_normal(4, 2, "R7");

    run(4, 2, 1000000, 0, 0);
    chk(r_escl == 1, "R7", "err_scl on endless stretch", int'(r_escl), 1);
    chk(episodes == 1, "R7", "stopped after first pulse", episodes, 1);

    run(5, 3, 0, 0, 1);
    check_normal(5, 3, "R9");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule